// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

A datapath slice for a 32-bit soft processor's execute stage. It takes two operands and a three-bit operation code and returns one result word. There are five operations. Two compare operations, one signed and one unsigned, return the difference `b - a` with its top bit adjusted so that software can read it directly as a less-than flag. A byte-lane matcher reports the first equal byte lane, counting from the most significant lane. A leading-zero counter works on operand `a`. A carry helper returns the carry out of `a + b + carry_in`.

The width of the operands, the width of a lane and the output stage are all parameters. When `REGISTERED` is 1 (the default), the result is captured on a rising clock edge while `in_valid` is high, and `out_valid` follows one cycle later. When `REGISTERED` is 0, the result is combinational and `out_valid` mirrors `in_valid`.

Top module: `int_cmp_unit`

## Requirements
- R1: For code 0 (signed compare), result bits 30..0 equal bits 30..0 of `b - a` taken modulo 2^32.
- R2: For code 0, when bit 31 of `a` and bit 31 of `b` differ, result bit 31 equals bit 31 of `b`; when they agree, it equals bit 31 of `b - a`.
- R3: For code 1 (unsigned compare), bits 30..0 are as in R1; when the top bits differ, result bit 31 equals bit 31 of `a`; otherwise it equals bit 31 of `b - a`.
- R4: For code 2 (byte match), the bytes of `a` and `b` are compared starting at bits 31..24. The result is 1, 2, 3 or 4 for the first equal lane (lane 1 is bits 31..24 and lane 4 is bits 7..0), and 0 when no lane is equal.
- R5: For code 3 (leading zeros), the result is the number of zero bits above the highest set bit of `a`, and 32 when `a` is zero.
- R6: For code 4 (carry), result bit 0 is 1 when `b` is all ones and `carry_in` is 1, or when `a + b + carry_in` exceeds 32 bits. All other result bits are 0.
- R7: Codes 5, 6 and 7 return a result of zero.
- R8: With the registered variant, a rising edge with `in_valid` high loads the result and sets `out_valid` for the next cycle. A rising edge with `in_valid` low clears `out_valid` and leaves the result unchanged.
- R9: While `rst_n` is low, `out_valid` and `result` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operands and code are valid this cycle |
| op | input | 3 | Operation code (0 to 7) |
| opnd_a | input | 32 | Operand a |
| opnd_b | input | 32 | Operand b |
| carry_in | input | 1 | Carry input for code 4 |
| result | output | 32 | Result word |
| out_valid | output | 1 | The result is valid |

## Verification
The only state in this block is the output register and its valid bit. A wrong captured value or a lost capture therefore shows at the ports on the very next cycle: either as a result that differs from the computed reference, or as a valid bit that does not follow `in_valid` one cycle later. An error in the datapath, such as the wrong operand's sign bit or a wrong lane order, also shows one cycle after the operands are applied. For this reason the bench places operands with differing top bits, lanes that match at every position, and carry inputs at the edge of overflow.

// File: rtl/int_cmp_pkg.sv
package int_cmp_pkg;
   typedef enum logic [2:0] {
      OP_SCMP   = 3'd0,
      OP_UCMP   = 3'd1,
      OP_BMATCH = 3'd2,
      OP_LZC    = 3'd3,
      OP_CARRY  = 3'd4
   } cmp_op_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/cmp_sign_fix.sv
// Difference b - a, with the top bit replaced by one operand's top bit
// when the two operands disagree in sign.
module cmp_sign_fix #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             unsigned_mode,
   output logic [WIDTH-1:0] out
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] diff;
   logic             signs_differ;

   assign diff         = b + ~a + WIDTH'(1);
   assign signs_differ = a[MSB] ^ b[MSB];

   always_comb begin
      out = diff;
      if (signs_differ) begin
         out[MSB] = unsigned_mode ? a[MSB] : b[MSB];
      end
   end
endmodule

// File: rtl/lane_matcher.sv
// Reports the first equal lane, counting from the most significant lane
// as position 1; 0 when no lane is equal.
module lane_matcher #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int LANES = WIDTH / LANE_W,
   localparam int POS_W = $clog2(LANES + 1)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [POS_W-1:0] pos
);
   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int HI = WIDTH - 1 - g * LANE_W;
      assign lane_eq[g] = (a[HI -: LANE_W] == b[HI -: LANE_W]);
   end

   always_comb begin
      pos = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (lane_eq[i]) pos = POS_W'(i + 1);
      end
   end
endmodule

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
   parameter int WIDTH = 32,
   localparam int CNT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] v,
   output logic [CNT_W-1:0] cnt
);
   always_comb begin
      cnt = CNT_W'(WIDTH);
      for (int i = 0; i < WIDTH; i++) begin
         if (v[i]) cnt = CNT_W'(WIDTH - 1 - i);
      end
   end
endmodule

// File: rtl/carry_detect.sv
module carry_detect #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic             cout
);
   logic [WIDTH:0] sum;

   assign sum  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
   assign cout = ((&b) & cin) | sum[WIDTH];
endmodule

// File: rtl/int_cmp_unit.sv
module int_cmp_unit
   import int_cmp_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int LANE_W     = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             out_valid
);
   localparam int LANES = WIDTH / LANE_W;
   localparam int POS_W = $clog2(LANES + 1);
   localparam int CNT_W = $clog2(WIDTH + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("int_cmp_unit: WIDTH must be at least 2");
   end
   if (LANE_W < 1 || (WIDTH % LANE_W) != 0) begin : g_bad_lane
      $error("int_cmp_unit: LANE_W must divide WIDTH");
   end

   logic [WIDTH-1:0] scmp_q, ucmp_q, next_res;
   logic [POS_W-1:0] match_pos;
   logic [CNT_W-1:0] lz_cnt;
   logic             carry_bit;

   cmp_sign_fix #(.WIDTH(WIDTH)) u_scmp (
      .a(opnd_a), .b(opnd_b), .unsigned_mode(1'b0), .out(scmp_q)
   );
   cmp_sign_fix #(.WIDTH(WIDTH)) u_ucmp (
      .a(opnd_a), .b(opnd_b), .unsigned_mode(1'b1), .out(ucmp_q)
   );
   lane_matcher #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_match (
      .a(opnd_a), .b(opnd_b), .pos(match_pos)
   );
   lead_zero_count #(.WIDTH(WIDTH)) u_lzc (
      .v(opnd_a), .cnt(lz_cnt)
   );
   carry_detect #(.WIDTH(WIDTH)) u_carry (
      .a(opnd_a), .b(opnd_b), .cin(carry_in), .cout(carry_bit)
   );

   always_comb begin
      unique case (op)
         OP_SCMP:   next_res = scmp_q;
         OP_UCMP:   next_res = ucmp_q;
         OP_BMATCH: next_res = {{(WIDTH-POS_W){1'b0}}, match_pos};
         OP_LZC:    next_res = {{(WIDTH-CNT_W){1'b0}}, lz_cnt};
         OP_CARRY:  next_res = {{(WIDTH-1){1'b0}}, carry_bit};
         default:   next_res = '0;
      endcase
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
         end
      end
   end else begin : g_comb
      assign result    = rst_n ? next_res : '0;
      assign out_valid = rst_n & in_valid;
   end
endmodule

// File: rtl/int_cmp_unit_chk.sv
module int_cmp_unit_chk #(
   parameter int WIDTH      = 32,
   parameter int LANE_W     = 8,
   parameter bit REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       op,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             out_valid
);
   localparam int MSB   = WIDTH - 1;
   localparam int LANES = WIDTH / LANE_W;

   logic [WIDTH-1:0] ref_diff;
   assign ref_diff = opnd_b - opnd_a;

   if (REGISTERED) begin : g_chk
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result));
      a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd0) |=> result[MSB-1:0] == $past(ref_diff[MSB-1:0]));
      a_r2_sign_from_b: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd0 && (opnd_a[MSB] != opnd_b[MSB]))
         |=> result[MSB] == $past(opnd_b[MSB]));
      a_r3_sign_from_a: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd1 && (opnd_a[MSB] != opnd_b[MSB]))
         |=> result[MSB] == $past(opnd_a[MSB]));
      a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd2) |=> result <= WIDTH'(LANES));
      a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd3) |=> result <= WIDTH'(WIDTH));
      a_r6_ones_with_cin: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd4 && carry_in && (&opnd_b)) |=> result == WIDTH'(1));
      a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd4) |=> result[MSB:1] == '0);
      a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op > 3'd4) |=> result == '0);
   end else begin : g_chk_comb
      always_comb begin
         if (rst_n && in_valid && op > 3'd4)
            a_r7_unused_zero_c: assert (result == '0);
      end
   end
endmodule

bind int_cmp_unit int_cmp_unit_chk #(
   .WIDTH(WIDTH), .LANE_W(LANE_W), .REGISTERED(REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
   .result(result), .out_valid(out_valid)
);

// File: tb/sim_int_cmp_unit.sv
module sim_int_cmp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [2:0]   op = '0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] result;
   logic         out_valid;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [W-1:0] exp_res = '0;
   logic         exp_v = 1'b0;
   logic [2:0]   exp_op = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_cmp_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .result(result), .out_valid(out_valid)
   );

   function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] a,
                                          input logic [W-1:0] b, input logic c);
      logic [W-1:0] d;
      longint unsigned s;
      int n;
      case (o)
         3'd0, 3'd1: begin
            d = b - a;
            if (a[31] != b[31]) d[31] = (o == 3'd0) ? b[31] : a[31];
            return d;
         end
         3'd2: begin
            for (int k = 0; k < 4; k++)
               if (a[31-8*k -: 8] == b[31-8*k -: 8]) return W'(k + 1);
            return '0;
         end
         3'd3: begin
            n = 0;
            while (n < 32 && a[31-n] == 1'b0) n++;
            return W'(n);
         end
         3'd4: begin
            s = longint'(a) + longint'(b) + longint'(c);
            return ((b == 32'hFFFF_FFFF && c) || s > 64'hFFFF_FFFF) ? W'(1) : '0;
         end
         default: return '0;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] o);
      case (o)
         3'd0: return "R1/R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         default: return "R7";
      endcase
   endfunction

   // behavioural reference, advanced on every clock
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_res <= '0;
         exp_v   <= 1'b0;
      end else begin
         exp_v <= in_valid;
         if (in_valid) begin
            exp_res <= model(op, opnd_a, opnd_b, carry_in);
            exp_op  <= op;
         end
      end
   end

   task automatic compare(input string req);
      checks++;
      if (out_valid !== exp_v || result !== exp_res) begin
         fails++;
         $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                  req, result, out_valid, exp_res, exp_v);
      end
   endtask

   // drive at negedge after comparing the previous cycle
   task automatic step(input bit v, input logic [2:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
      @(negedge clk);
      compare(exp_v ? tag(exp_op) : "R8");
      in_valid = v; op = o; opnd_a = a; opnd_b = b; carry_in = c;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R9");  // reset state
      rst_n = 1'b1;
      // R1 R2 signed compare
      step(1, 3'd0, 32'd5, 32'd3, 0);
      step(1, 3'd0, 32'h8000_0000, 32'd1, 0);      // expect 0000_0001
      step(1, 3'd0, 32'd1, 32'h8000_0000, 0);
      step(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
      // R3 unsigned compare
      step(1, 3'd1, 32'h8000_0000, 32'd1, 0);      // expect 8000_0001
      step(1, 3'd1, 32'd7, 32'hF000_0000, 0);
      step(1, 3'd1, 32'd9, 32'd2, 0);
      // R4 byte match
      step(1, 3'd2, 32'h1122_3344, 32'h1122_3344, 0);  // 1
      step(1, 3'd2, 32'h1122_3344, 32'h9922_3344, 0);  // 2
      step(1, 3'd2, 32'h1122_3344, 32'h9999_3300, 0);  // 3
      step(1, 3'd2, 32'h1122_3344, 32'h0000_0044, 0);  // 4
      step(1, 3'd2, 32'h1122_3344, 32'hEEDD_CCBB, 0);  // 0
      // R5 leading zeros
      step(1, 3'd3, 32'h0, 32'h0, 0);
      step(1, 3'd3, 32'h1, 32'h0, 0);
      step(1, 3'd3, 32'h8000_0000, 32'h0, 0);
      step(1, 3'd3, 32'h0001_2345, 32'h0, 0);
      // R6 carry
      step(1, 3'd4, 32'h0, 32'hFFFF_FFFF, 1);
      step(1, 3'd4, 32'h1, 32'hFFFF_FFFE, 0);
      step(1, 3'd4, 32'h1, 32'hFFFF_FFFE, 1);
      step(1, 3'd4, 32'h2, 32'hFFFF_FFFF, 0);
      // R7 unused codes
      step(1, 3'd5, 32'h1234, 32'h1234, 1);
      step(1, 3'd6, 32'hFFFF_FFFF, 32'h0, 1);
      step(1, 3'd7, 32'h0, 32'h0, 1);
      // R8 hold while idle with changing inputs
      step(1, 3'd0, 32'd10, 32'd20, 0);
      step(0, 3'd3, 32'h0, 32'hABCD, 1);
      step(0, 3'd1, 32'h5, 32'h9, 0);
      step(1, 3'd2, 32'hAA00_0000, 32'hAA00_0000, 0);
      // mixed patterns
      for (int i = 0; i < 200; i++)
         step(($urandom % 4) != 0, 3'($urandom % 8), $urandom, $urandom, 1'($urandom));
      step(0, 3'd0, 0, 0, 0);
      @(negedge clk);
      compare("R8");
      // R9 reset clears
      rst_n = 1'b0;
      #1;
      compare("R9");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule